// File: doc/BRIEF.md
# Acquisition Front-End Configuration Register

This block holds the six-bit configuration word of a multichannel converter front end: a three-bit channel address, a software conversion request bit, a low-power standby bit and an output-format bit. The word can be loaded in one of two ways, selected by a static mode input. In parallel mode, a write strobe captures the word from a six-bit data bus. In serial mode, a framed serial port shifts the word in one bit per serial clock while an active-low frame signal is held low.

All external timing inputs (serial clock, frame, serial data and write strobe) are brought into the system clock domain through two-flop synchronisers, and their edges are found there. The register drives the channel select, the one-based channel number, the standby and format levels, and the software-convert level to the conversion sequencer. It also raises two single-cycle events. One fires when a completed write changes the channel address. The other fires when a write requests a software conversion.

A serial frame commits only after six complete serial clocks. A frame that ends early is thrown away. Even so, if the software-convert bit is already set when that short frame ends, it still starts a new conversion.

Top module: `acq_ctrl_reg`

## Requirements
- R1: While `rstN` is low at a clock edge, every configuration output and both event outputs are 0 after that edge, so `chanNum` reads 1.
- R2: With `modeParallel` = 1, a rising edge of `wrStrobe` loads the word from `parData`. The fields are `parData[5:3]` = channel address, `[2]` = software convert, `[1]` = standby and `[0]` = two's-complement format.
- R3: With `modeParallel` = 0, serial data is sampled on each falling edge of `sclk` while `frameN` is low. The bits arrive in this order: address MSB, address middle bit, address LSB, software convert, standby, format. When `frameN` rises after six samples, the word takes effect.
- R4: A serial frame that ends with fewer than six falling `sclk` edges leaves the stored word unchanged.
- R5: A short serial frame that ends while the stored software-convert bit is 1 produces one `swStartEvt` pulse. When that bit is 0, it produces none.
- R6: Serial bits after the sixth in the same frame are ignored.
- R7: `chanNum` equals the channel address plus one, so it always lies in the range 1 to 8.
- R8: In serial mode the write strobe has no effect. In parallel mode, serial frames have no effect.
- R9: `addrWrEvt` pulses for exactly one cycle after a completed write whose address differs from the stored address, and at no other time.
- R10: `swStartEvt` pulses for exactly one cycle after a completed write with the software-convert bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeParallel | input | 1 | 1 = load from the parallel bus, 0 = load through the serial port |
| wrStrobe | input | 1 | Parallel write strobe; loads on its rising edge |
| parData | input | 6 | Parallel configuration word |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| frameN | input | 1 | Active-low serial frame |
| sdin | input | 1 | Serial data in |
| chanSel | output | 3 | Stored channel address |
| chanNum | output | 4 | One-based channel number |
| swConv | output | 1 | Stored software-convert bit |
| standby | output | 1 | Stored standby bit |
| fmtTwos | output | 1 | Stored format bit (1 = two's complement) |
| addrWrEvt | output | 1 | One-cycle pulse: address changed by a write |
| swStartEvt | output | 1 | One-cycle pulse: software conversion start |

## Verification
The hardest case to reach from the ports is the short frame that must still start a conversion. It requires the software-convert bit to be set first by a complete serial frame. After that, a frame of only two clocks must end with no change to the stored word and exactly one start pulse. The stimulus sets the bit with a full frame and then sends the truncated frame. A second truncated frame is sent while the bit is clear, to show that no pulse appears in that case. Eight-bit frames and writes on the inactive interface check that extra or unselected activity does not change the word.

// File: rtl/acqcfg_pkg.sv
package acqcfg_pkg;
  localparam int ADDR_W = 3;
  localparam int CFG_W  = ADDR_W + 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              swConv;
    logic              standby;
    logic              fmtTwos;
  } cfgWord_t;

  typedef struct packed {
    logic shiftEn;
    logic loadSer;
    logic loadPar;
    logic shortEnd;
  } ctrlStrb_t;
endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/acq_cfg_ctrl.sv
module acq_cfg_ctrl
  import acqcfg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeParallel,
  input  logic      sclkS,
  input  logic      frameNS,
  input  logic      wrS,
  output ctrlStrb_t strb
);
  localparam int CNT_W = $clog2(CFG_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(CFG_W);

  logic sclkPrev, framePrev, wrPrev;
  logic [CNT_W-1:0] bitCnt;
  logic sclkFall, frameRise, frameFall, wrRise, full, serialMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      framePrev <= 1'b1;
      wrPrev    <= 1'b0;
    end else begin
      sclkPrev  <= sclkS;
      framePrev <= frameNS;
      wrPrev    <= wrS;
    end
  end

  always_comb begin
    serialMode = ~modeParallel;
    sclkFall   = sclkPrev & ~sclkS;
    frameRise  = frameNS & ~framePrev;
    frameFall  = ~frameNS & framePrev;
    wrRise     = wrS & ~wrPrev;
    full       = (bitCnt == FULL_CNT);
    strb.shiftEn  = serialMode & ~frameNS & sclkFall & ~full;
    strb.loadSer  = serialMode & frameRise & full;
    strb.shortEnd = serialMode & frameRise & ~full;
    strb.loadPar  = modeParallel & wrRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             bitCnt <= '0;
    else if (frameFall)    bitCnt <= '0;
    else if (strb.shiftEn) bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/acq_cfg_dp.sv
module acq_cfg_dp
  import acqcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic             sdinS,
  input  logic [CFG_W-1:0] parData,
  output cfgWord_t         cfg,
  output logic             addrWrEvt,
  output logic             swStartEvt
);
  logic [CFG_W-1:0] shiftReg;
  cfgWord_t         nextWord;
  logic             loadAny;

  always_ff @(posedge clk) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[CFG_W-2:0], sdinS};
  end

  always_comb begin
    loadAny  = strb.loadSer | strb.loadPar;
    nextWord = strb.loadPar ? cfgWord_t'(parData) : cfgWord_t'(shiftReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg        <= '0;
      addrWrEvt  <= 1'b0;
      swStartEvt <= 1'b0;
    end else begin
      addrWrEvt  <= loadAny & (nextWord.addr != cfg.addr);
      swStartEvt <= (loadAny & nextWord.swConv) | (strb.shortEnd & cfg.swConv);
      if (loadAny) cfg <= nextWord;
    end
  end
endmodule

// File: rtl/acq_ctrl_reg.sv
module acq_ctrl_reg
  import acqcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeParallel,
  input  logic              wrStrobe,
  input  logic [CFG_W-1:0]  parData,
  input  logic              sclk,
  input  logic              frameN,
  input  logic              sdin,
  output logic [ADDR_W-1:0] chanSel,
  output logic [ADDR_W:0]   chanNum,
  output logic              swConv,
  output logic              standby,
  output logic              fmtTwos,
  output logic              addrWrEvt,
  output logic              swStartEvt
);
  logic [3:0] rawIn, syncOut;
  ctrlStrb_t  strb;
  cfgWord_t   cfg;

  assign rawIn = {sclk, frameN, sdin, wrStrobe};

  acq_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncOut)
  );

  acq_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeParallel(modeParallel),
    .sclkS(syncOut[3]), .frameNS(syncOut[2]), .wrS(syncOut[0]), .strb(strb)
  );

  acq_cfg_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdinS(syncOut[1]), .parData(parData),
    .cfg(cfg), .addrWrEvt(addrWrEvt), .swStartEvt(swStartEvt)
  );

  assign chanSel = cfg.addr;
  assign chanNum = (ADDR_W+1)'(cfg.addr) + 1'b1;
  assign swConv  = cfg.swConv;
  assign standby = cfg.standby;
  assign fmtTwos = cfg.fmtTwos;
endmodule

// File: rtl/acq_ctrl_reg_chk.sv
module acq_ctrl_reg_chk
  import acqcfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] chanSel,
  input logic [ADDR_W:0]   chanNum,
  input logic              swConv,
  input logic              standby,
  input logic              fmtTwos,
  input logic              addrWrEvt,
  input logic              swStartEvt
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (chanSel == '0 && !swConv && !standby && !fmtTwos && !addrWrEvt && !swStartEvt)); // R1

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (chanNum >= 1 && chanNum <= (1 << ADDR_W))); // R7

  AST_ADDR_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    addrWrEvt |=> !addrWrEvt); // R9

  AST_ADDR_MOVES_WITH_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (chanSel != $past(chanSel)) |-> addrWrEvt); // R9

  AST_START_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    swStartEvt |=> !swStartEvt); // R10
endmodule

bind acq_ctrl_reg acq_ctrl_reg_chk u_chk (
  .clk(clk), .rstN(rstN), .chanSel(chanSel), .chanNum(chanNum), .swConv(swConv),
  .standby(standby), .fmtTwos(fmtTwos), .addrWrEvt(addrWrEvt), .swStartEvt(swStartEvt)
);

// File: tb/tb_acq_ctrl_reg.sv
module tb_acq_ctrl_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeParallel = 1'b1;
  logic wrStrobe = 1'b0;
  logic [5:0] parData = '0;
  logic sclk = 1'b0;
  logic frameN = 1'b1;
  logic sdin = 1'b0;
  logic [2:0] chanSel;
  logic [3:0] chanNum;
  logic swConv, standby, fmtTwos, addrWrEvt, swStartEvt;

  always #5 clk = ~clk;

  acq_ctrl_reg dut (
    .clk(clk), .rstN(rstN), .modeParallel(modeParallel), .wrStrobe(wrStrobe),
    .parData(parData), .sclk(sclk), .frameN(frameN), .sdin(sdin),
    .chanSel(chanSel), .chanNum(chanNum), .swConv(swConv), .standby(standby),
    .fmtTwos(fmtTwos), .addrWrEvt(addrWrEvt), .swStartEvt(swStartEvt)
  );

  typedef struct {
    string      tag;
    logic [5:0] word;
    int         addrPulses;
    int         startPulses;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int addrCnt = 0;
  int startCnt = 0;
  logic [5:0] model = '0;
  event txnDone;

  always @(negedge clk) begin
    if (addrWrEvt)  addrCnt++;
    if (swStartEvt) startCnt++;
  end

  task automatic check(string tag, int got, int exp, string what);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  initial begin
    forever begin
      @(txnDone);
      if (expQ.size() != 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.tag, int'({chanSel, swConv, standby, fmtTwos}), int'(e.word), "word");
        check("R7", int'(chanNum), int'(e.word[5:3]) + 1, "chanNum");
        check(e.tag, addrCnt, e.addrPulses, "addrWrEvt pulses");
        check(e.tag, startCnt, e.startPulses, "swStartEvt pulses");
      end
      addrCnt = 0;
      startCnt = 0;
    end
  end

  task automatic settle(string tag, logic [5:0] newModel, int ap, int sp);
    expItem_t e;
    repeat (10) @(posedge clk);
    e.tag = tag; e.word = newModel; e.addrPulses = ap; e.startPulses = sp;
    expQ.push_back(e);
    model = newModel;
    #1 -> txnDone;
    #1;
  endtask

  task automatic parWrite(logic [5:0] w);
    @(negedge clk);
    parData = w;
    wrStrobe = 1'b1;
    repeat (4) @(negedge clk);
    wrStrobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic serFrame(logic [7:0] bits, int nBits);
    @(negedge clk);
    frameN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      sdin = bits[7-i];
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    frameN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    settle("R1", 6'b000000, 0, 0);

    parWrite(6'b101001);                       // R2 address change, format
    settle("R2", 6'b101001, 1, 0);
    parWrite(6'b101100);                       // R10 same address, software start
    settle("R10", 6'b101100, 0, 1);

    modeParallel = 1'b0;
    repeat (4) @(negedge clk);
    parWrite(6'b111111);                       // R8 strobe ignored in serial mode
    settle("R8", model, 0, 0);

    serFrame({6'b111010, 2'b00}, 6);           // R3 full frame
    settle("R3", 6'b111010, 1, 0);
    serFrame(8'b00000000, 3);                  // R4 short frame, convert bit clear
    settle("R4", model, 0, 0);
    serFrame({6'b000100, 2'b00}, 6);           // R10 serial write with start
    settle("R10", 6'b000100, 1, 1);
    serFrame(8'b11000000, 2);                  // R5 short frame with convert bit set
    settle("R5", model, 0, 1);
    serFrame({6'b010001, 2'b11}, 8);           // R6 two extra bits
    settle("R6", 6'b010001, 1, 0);

    modeParallel = 1'b1;
    repeat (4) @(negedge clk);
    serFrame({6'b110110, 2'b00}, 6);           // R8 serial ignored in parallel mode
    settle("R8", model, 0, 0);

    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle("R1", 6'b000000, 0, 0);

    parWrite(6'b011010);                       // R9 address change after reset
    settle("R9", 6'b011010, 1, 0);
    parWrite(6'b011010);                       // R9 rewrite same address: no pulse
    settle("R9", 6'b011010, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule